// File: doc/BRIEF.md
# Lockable Thermal Alert Controller

This block watches a set of temperature readings and drives a single active-low alert pin whenever a watched reading leaves an allowed window. There is one reading for the chip itself and one for each of four memory modules. All readings are checked against one shared window, given by an upper and a lower limit. An 8-bit control register, written and read through a simple port, selects which groups of readings can raise the alert. A separate per-module enable vector chooses which memory modules count.

Firmware programs the control register during boot. It can then set the register's lock bit, which freezes the whole register, including the lock bit, until a warm reset or a cold reset clears it. The alert pin is registered. It follows the enabled out-of-window condition with one clock of latency.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: While the cold reset is low and for the cycles just after it is released, the control register reads 00h and alert_n is high.
- R2: While unlocked, a write stores wr_data bits 7, 4 and 3 into the register on the clock edge. Bits 6:5 and 2:0 always read 0, and rd_data always shows the current register value without a clock of delay.
- R3: Once bit 7 (lock) reads 1, a write leaves every register bit unchanged, including bit 7.
- R4: A synchronous warm reset clears the whole register, including the lock, on the next edge and drives alert_n high on that same edge. It takes priority over a write in the same cycle.
- R5: When register bit 4 is 1, the alert asserts if local_temp is strictly greater than limit_hi or strictly less than limit_lo. A reading equal to either limit is in range. All values are unsigned.
- R6: When register bit 3 is 1, the alert asserts if any module i whose mod_en[i] is 1 has mod_temp[8*i+7:8*i] outside the window. A module with mod_en[i] at 0 never causes an alert.
- R7: All four modules and the local reading are compared against the same limit_hi and limit_lo pair. With bits 4 and 3 both 0, the alert never asserts.
- R8: alert_n is registered and active low. After the edge that samples the inputs and the register, it is low if an enabled source was out of range and high otherwise, so it releases one edge after the last enabled source returns to range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| local_temp | input | 8 | Chip temperature reading |
| mod_temp | input | 32 | Module readings, module i in bits 8i+7:8i |
| mod_en | input | 4 | Per-module participation enables |
| limit_hi | input | 8 | Upper limit, inclusive in-range |
| limit_lo | input | 8 | Lower limit, inclusive in-range |
| alert_n | output | 1 | Temperature alert, active low |

## Verification
On every cycle, the assertions check that a locked register holds its value, that a warm reset empties it, and that an unlocked write lands in it masked to the implemented bits. They also check that the alert pin falls after any enabled out-of-range source and rises when no enabled source is out of range. Other behaviours can only be shown by the bench's scenarios. These are the exact limit-equality boundaries, a disabled module whose reading is out of range while the pin stays quiet, a write racing a warm reset, and the locked register staying frozen across long random traffic until a warm reset releases it. These scenarios are checked against a reference model written from the requirements.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned LOCK_BIT   = 7;
  localparam int unsigned LOCAL_BIT  = 4;
  localparam int unsigned MODULE_BIT = 3;
  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << LOCK_BIT) | (REG_W'(1) << LOCAL_BIT) | (REG_W'(1) << MODULE_BIT);
endpackage

// File: rtl/tac_rst_sync.sv
module tac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tac_ctl_reg.sv
module tac_ctl_reg
  import tac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] ctl_d;
  logic             ctl_ce;
  logic             locked;

  assign locked = ctl_q[LOCK_BIT];

  always_comb begin
    ctl_ce = warm_rst | (wr_en & ~locked);
    ctl_d  = ctl_q;
    if (warm_rst)                ctl_d = '0;
    else if (wr_en && !locked)   ctl_d = wr_data & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end

  // R3: a locked register holds everything, including the lock
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !warm_rst) |=> $stable(ctl_q));

  // R4: warm reset empties the register
  p_warm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (ctl_q == '0));

  // R2: unlocked write lands, masked to the implemented bits
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && !warm_rst) |=> (ctl_q == ($past(wr_data) & WR_MASK)));
endmodule

// File: rtl/tac_range_chk.sv
module tac_range_chk #(
  parameter int unsigned TEMP_W  = 8,
  parameter int unsigned NUM_SRC = 5
) (
  input  logic [NUM_SRC*TEMP_W-1:0] temps,
  input  logic [TEMP_W-1:0]         limit_hi,
  input  logic [TEMP_W-1:0]         limit_lo,
  output logic [NUM_SRC-1:0]        oor
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [TEMP_W-1:0] t;
    assign t      = temps[g*TEMP_W +: TEMP_W];
    assign oor[g] = (t > limit_hi) || (t < limit_lo);
  end
endmodule

// File: rtl/tac_alert_out.sv
module tac_alert_out #(
  parameter int unsigned NUM_MOD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               warm_rst,
  input  logic               local_alert_en,
  input  logic               mod_alert_en,
  input  logic               local_oor,
  input  logic [NUM_MOD-1:0] mod_oor,
  input  logic [NUM_MOD-1:0] mod_en,
  output logic               alert_n
);
  logic any_mod;
  logic req;
  logic alert_n_d;

  always_comb begin
    any_mod   = |(mod_oor & mod_en);
    req       = (local_alert_en & local_oor) | (mod_alert_en & any_mod);
    alert_n_d = warm_rst ? 1'b1 : ~req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= alert_n_d;
  end

  // R5: enabled local excursion pulls the pin low
  p_local_asserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (local_alert_en && local_oor && !warm_rst) |=> !alert_n);

  // R6: enabled module excursion pulls the pin low
  p_mod_asserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_alert_en && |(mod_oor & mod_en) && !warm_rst) |=> !alert_n);

  // R8: quiet sources release the pin
  p_quiet_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(local_alert_en && local_oor) && !(mod_alert_en && |(mod_oor & mod_en))) |=> alert_n);
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import tac_pkg::*;
#(
  parameter int unsigned TEMP_W  = 8,
  parameter int unsigned NUM_MOD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      warm_rst,
  input  logic                      wr_en,
  input  logic [REG_W-1:0]          wr_data,
  output logic [REG_W-1:0]          rd_data,
  input  logic [TEMP_W-1:0]         local_temp,
  input  logic [NUM_MOD*TEMP_W-1:0] mod_temp,
  input  logic [NUM_MOD-1:0]        mod_en,
  input  logic [TEMP_W-1:0]         limit_hi,
  input  logic [TEMP_W-1:0]         limit_lo,
  output logic                      alert_n
);
  localparam int unsigned NUM_SRC = NUM_MOD + 1;

  logic               rst_sync_n;
  logic [REG_W-1:0]   ctl_q;
  logic [NUM_SRC-1:0] oor;

  tac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tac_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .warm_rst (warm_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctl_q    (ctl_q)
  );

  tac_range_chk #(.TEMP_W(TEMP_W), .NUM_SRC(NUM_SRC)) u_range (
    .temps    ({mod_temp, local_temp}),
    .limit_hi (limit_hi),
    .limit_lo (limit_lo),
    .oor      (oor)
  );

  tac_alert_out #(.NUM_MOD(NUM_MOD)) u_alert (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .warm_rst       (warm_rst),
    .local_alert_en (ctl_q[LOCAL_BIT]),
    .mod_alert_en   (ctl_q[MODULE_BIT]),
    .local_oor      (oor[0]),
    .mod_oor        (oor[NUM_SRC-1:1]),
    .mod_en         (mod_en),
    .alert_n        (alert_n)
  );

  assign rd_data = ctl_q;

  // R2: unimplemented bits never read back as 1
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_data & ~WR_MASK) == '0));

  // R7: with both group enables off the pin stays high
  p_all_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_q[LOCAL_BIT] && !ctl_q[MODULE_BIT]) |=> alert_n);
endmodule

// File: tb/test_thermal_alert_ctrl.sv
module test_thermal_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, warm_rst, wr_en;
  logic [7:0]  wr_data, rd_data, local_temp, limit_hi, limit_lo;
  logic [31:0] mod_temp;
  logic [3:0]  mod_en;
  logic        alert_n;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_reg;
  int unsigned seed;

  always #2 clk = ~clk;

  thermal_alert_ctrl i_thermal_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .local_temp(local_temp),
    .mod_temp(mod_temp), .mod_en(mod_en), .limit_hi(limit_hi),
    .limit_lo(limit_lo), .alert_n(alert_n)
  );

  function automatic bit out_of(input logic [7:0] t, hi, lo);
    return (t > hi) || (t < lo);
  endfunction

  function automatic bit want_alert(input logic [7:0] r);
    bit a = r[4] && out_of(local_temp, limit_hi, limit_lo);
    for (int i = 0; i < 4; i++)
      if (r[3] && mod_en[i] && out_of(mod_temp[8*i +: 8], limit_hi, limit_lo)) a = 1;
    return a;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // inputs already driven at negedge; advance one edge and compare
  task automatic step(input string req);
    logic [7:0] nreg;
    bit exp_al;
    exp_al = want_alert(m_reg);
    nreg = m_reg;
    if (warm_rst) begin nreg = 8'h00; exp_al = 0; end
    else if (wr_en && !m_reg[7]) nreg = wr_data & 8'h98;
    @(posedge clk);
    @(negedge clk);
    m_reg = nreg;
    check8({req, " reg"}, rd_data, m_reg);
    check8({req, " alert_n"}, {7'd0, alert_n}, {7'd0, ~exp_al});
  endtask

  task automatic idle();
    wr_en = 0; warm_rst = 0;
  endtask

  initial begin
    rst_n = 0; warm_rst = 0; wr_en = 0; wr_data = 0;
    local_temp = 8'd50; mod_temp = {4{8'd50}}; mod_en = 0;
    limit_hi = 8'd80; limit_lo = 8'd20;
    m_reg = 0;
    repeat (3) @(negedge clk);
    check8("R1 reg in reset", rd_data, 8'h00);
    check8("R1 alert_n in reset", {7'd0, alert_n}, 8'h01);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check8("R1 reg after release", rd_data, 8'h00);

    // R2: write all ones, only 7/4/3 implemented; leave lock clear first
    wr_en = 1; wr_data = 8'h7F; step("R2 masked write");
    check8("R2 value", rd_data, 8'h18);
    idle(); step("R2 idle");

    // R5 boundaries: equal to limits is in range
    local_temp = 8'd80; step("R5 equal hi");
    local_temp = 8'd81; step("R5 above hi");
    local_temp = 8'd20; step("R8 release at lo");
    local_temp = 8'd19; step("R5 below lo");
    local_temp = 8'd50; step("R8 release");

    // R6: disabled module ignored, enabled module alerts
    mod_temp[8*2 +: 8] = 8'd200; mod_en = 4'b1011; step("R6 disabled module");
    check8("R6 disabled quiet", {7'd0, alert_n}, 8'h01);
    mod_en = 4'b0100; step("R6 enabled module");
    check8("R6 enabled alerts", {7'd0, alert_n}, 8'h00);

    // R7: both group enables off -> quiet
    wr_en = 1; wr_data = 8'h00; step("R7 disable groups");
    idle(); local_temp = 8'd0; step("R7 all off");
    check8("R7 quiet", {7'd0, alert_n}, 8'h01);

    // R3: lock, then try to change
    wr_en = 1; wr_data = 8'h88; step("R3 set lock");
    wr_data = 8'h10; step("R3 write ignored");
    check8("R3 frozen", rd_data, 8'h88);
    wr_data = 8'h00; step("R3 lock cannot clear itself");

    // R4: warm reset wins over a write in the same cycle
    warm_rst = 1; wr_en = 1; wr_data = 8'h18; step("R4 warm vs write");
    check8("R4 cleared", rd_data, 8'h00);
    idle(); local_temp = 8'd50; mod_temp = {4{8'd50}};

    // constrained random traffic
    seed = 32'd20240601;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      warm_rst = ($urandom % 40) == 0;
      wr_en    = ($urandom % 4) == 0;
      wr_data  = $urandom;
      if (wr_data[7] && ($urandom % 4) != 0) wr_data[7] = 1'b0;
      limit_lo = 8'd40 + 8'($urandom % 20);
      limit_hi = 8'd140 + 8'($urandom % 20);
      local_temp = 8'd30 + 8'($urandom % 140);
      for (int i = 0; i < 4; i++) mod_temp[8*i +: 8] = 8'd30 + 8'($urandom % 140);
      mod_en = $urandom;
      step("R2 R3 R4 R5 R6 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule